// File: doc/BRIEF.md
# Calibration Offset and Gain Correction Pipeline

This block applies a two-step calibration to each converter sample. A signed offset is added to the raw code first. The sum is clamped to the code range, multiplied by an unsigned fixed-point gain, and clamped again. The correction runs in a fixed-latency pipeline that accepts one sample per clock. A stream of back-to-back samples therefore pays the pipeline delay once and then delivers one corrected result per clock.

Each sample travels with the offset and gain values that were presented beside it. When correction is switched off, samples go from input to output within the same cycle. A flush input removes every sample still in flight, so that no stale result comes out.

Top module: `cal_corr_stage`

## Requirements
- R1: With `en_i` high, the result of an accepted sample is `clamp((raw_i + ofs_i) * gain_i / 2048)`. Here `ofs_i` is 12-bit two's complement, `gain_i` is unsigned with 11 fraction bits (0x800 means 1.0), and the offset is applied before the gain.
- R2: The offset sum is clamped to 0..4095 before the multiplication. A negative sum becomes 0 and a sum above 4095 becomes 4095.
- R3: The product drops its 11 fraction bits by truncation and saturates at 4095.
- R4: With `en_i` high, `vld_o` rises exactly 13 cycles after the cycle in which a sample is presented with `vld_i` high. At all other times `vld_o` is low.
- R5: A new sample is accepted every cycle. Results leave in input order on consecutive cycles, and each result uses the offset and gain presented with its own sample.
- R6: With `en_i` low, `vld_o` equals `vld_i` and `res_o` equals `raw_i` in the same cycle.
- R7: A cycle with `flush_i` high discards every sample in flight as well as the sample presented in that cycle. Samples presented after it are corrected normally.
- R8: A cycle with `en_i` low discards every corrected sample in flight. After `en_i` returns high, no result comes out until new samples have passed through the pipeline.
- R9: While `rst_ni` is low and after reset, `vld_o` is low until a sample has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Correction enable; low selects same-cycle bypass |
| flush_i | input | 1 | Discard all samples in flight |
| vld_i | input | 1 | Raw sample valid |
| raw_i | input | 12 | Raw unsigned conversion code |
| ofs_i | input | 12 | Signed offset correction |
| gain_i | input | 12 | Unsigned gain correction, 11 fraction bits |
| vld_o | output | 1 | Result valid |
| res_o | output | 12 | Corrected (or bypassed) result |

## Verification
A table of isolated samples drives the arithmetic, one sample at a time:
- Unity gain with zero, positive and negative offset isolates the adder.
- Gains of 0.5, 1.5, just above 1.0, the maximum and zero isolate the multiplier and its truncation.
- Sums below zero and above full scale exercise both clamps.
- One vector uses a non-unity gain with a non-zero offset, so that offset-then-gain gives a different answer from gain-then-offset.

Each isolated sample also shows the exact 13-cycle delay. A long burst with offset and gain changing on every cycle separates correct per-sample pairing and ordering from a design that stalls or mixes up its coefficients. Flush and disable patterns injected into a busy pipeline show whether in-flight samples are truly discarded and whether the pipeline restarts cleanly.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned CAL_DATA_W  = 12;
  localparam int unsigned CAL_OFS_W   = 12;
  localparam int unsigned CAL_GAIN_W  = 12;
  localparam int unsigned CAL_FRAC_W  = 11;
  localparam int unsigned CAL_LATENCY = 13;
endpackage

// File: rtl/cal_ofs_stage.sv
module cal_ofs_stage #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned GAIN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kill_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] sum_o,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned SUM_W = ((DATA_W > OFS_W) ? DATA_W : OFS_W) + 2;
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((1 << DATA_W) - 1);

  logic signed [SUM_W-1:0] sum_s;
  logic [DATA_W-1:0]       sat_c;
  logic                    take;

  assign take  = vld_i & ~kill_i;
  assign sum_s = $signed({{(SUM_W-DATA_W){1'b0}}, raw_i})
               + $signed({{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});

  always_comb begin
    if (sum_s < 0)          sat_c = '0;
    else if (sum_s > MAX_S) sat_c = '1;
    else                    sat_c = sum_s[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      sum_o  <= '0;
      gain_o <= '0;
    end else begin
      vld_o <= take;
      if (take) begin
        sum_o  <= sat_c;
        gain_o <= gain_i;
      end
    end
  end

  AST_OFS_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && sum_s < 0) |=> (vld_o && sum_o == '0)); // R2
  AST_OFS_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && sum_s > MAX_S) |=> (vld_o && sum_o == '1)); // R2
endmodule

// File: rtl/cal_gain_stage.sv
module cal_gain_stage #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned GAIN_W = 12,
  parameter int unsigned FRAC_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kill_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned PROD_W = DATA_W + GAIN_W;
  localparam int unsigned SCL_W  = PROD_W - FRAC_W;
  localparam logic [SCL_W-1:0] MAX_S = SCL_W'((1 << DATA_W) - 1);

  logic              prod_vld_q;
  logic [PROD_W-1:0] prod_q;
  logic [PROD_W-1:0] prod_c;
  logic [SCL_W-1:0]  scaled;
  logic [DATA_W-1:0] res_c;

  assign prod_c = PROD_W'(sum_i) * PROD_W'(gain_i);
  assign scaled = prod_q[PROD_W-1:FRAC_W];
  assign res_c  = (scaled > MAX_S) ? '1 : scaled[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_vld_q <= 1'b0;
      prod_q     <= '0;
      vld_o      <= 1'b0;
      res_o      <= '0;
    end else begin
      prod_vld_q <= vld_i & ~kill_i;
      if (vld_i) prod_q <= prod_c;
      vld_o <= prod_vld_q & ~kill_i;
      if (prod_vld_q) res_o <= res_c;
    end
  end

  AST_GAIN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod_vld_q && !kill_i && scaled > MAX_S) |=> (vld_o && res_o == '1)); // R3
  AST_GAIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !kill_i && gain_i == '0) |=> (prod_vld_q && prod_q == '0)); // R1
endmodule

// File: rtl/cal_delay_line.sv
module cal_delay_line #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned DEPTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_i,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] dat_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] dat_o
);
  if (DEPTH == 0) begin : g_thru
    assign vld_o = vld_i & ~kill_i;
    assign dat_o = dat_i;
  end else begin : g_regs
    logic [DEPTH-1:0] vld_q;
    logic [WIDTH-1:0] dat_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
        for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
      end else begin
        vld_q[0] <= vld_i & ~kill_i;
        dat_q[0] <= dat_i;
        for (int i = 1; i < DEPTH; i++) begin
          vld_q[i] <= vld_q[i-1] & ~kill_i;
          dat_q[i] <= dat_q[i-1];
        end
      end
    end

    assign vld_o = vld_q[DEPTH-1];
    assign dat_o = dat_q[DEPTH-1];

    AST_KILL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_i |=> (vld_q == '0)); // R7

    for (genvar s = 1; s < DEPTH; s++) begin : g_chk
      AST_IN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !kill_i |=> (vld_q[s] == $past(vld_q[s-1]) && dat_q[s] == $past(dat_q[s-1]))); // R5
    end
  end
endmodule

// File: rtl/cal_corr_stage.sv
module cal_corr_stage
  import cal_pkg::*;
#(
  parameter int unsigned DATA_W  = CAL_DATA_W,
  parameter int unsigned OFS_W   = CAL_OFS_W,
  parameter int unsigned GAIN_W  = CAL_GAIN_W,
  parameter int unsigned FRAC_W  = CAL_FRAC_W,
  parameter int unsigned LATENCY = CAL_LATENCY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              flush_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned CORE_STAGES = 3;
  localparam int unsigned TAIL_DEPTH  = LATENCY - CORE_STAGES;

  logic              kill;
  logic              a_vld, c_vld, t_vld;
  logic [DATA_W-1:0] a_sum, c_res, t_res;
  logic [GAIN_W-1:0] a_gain;

  // disabling also empties the pipeline so no stale result leaks on re-enable
  assign kill = flush_i | ~en_i;

  cal_ofs_stage #(.DATA_W(DATA_W), .OFS_W(OFS_W), .GAIN_W(GAIN_W)) u_ofs (
    .clk_i(clk_i), .rst_ni(rst_ni), .kill_i(kill), .vld_i(vld_i),
    .raw_i(raw_i), .ofs_i(ofs_i), .gain_i(gain_i),
    .vld_o(a_vld), .sum_o(a_sum), .gain_o(a_gain)
  );

  cal_gain_stage #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_gain (
    .clk_i(clk_i), .rst_ni(rst_ni), .kill_i(kill), .vld_i(a_vld),
    .sum_i(a_sum), .gain_i(a_gain), .vld_o(c_vld), .res_o(c_res)
  );

  cal_delay_line #(.WIDTH(DATA_W), .DEPTH(TAIL_DEPTH)) u_tail (
    .clk_i(clk_i), .rst_ni(rst_ni), .kill_i(kill), .vld_i(c_vld),
    .dat_i(c_res), .vld_o(t_vld), .dat_o(t_res)
  );

  assign vld_o = en_i ? t_vld : vld_i;
  assign res_o = en_i ? t_res : raw_i;

  AST_REENABLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!en_i) && en_i) |-> !vld_o); // R8
  AST_FLUSH_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_i) && en_i) |-> !vld_o); // R7
endmodule

// File: tb/cal_corr_stage_bench.sv
`timescale 1ns/1ps
module cal_corr_stage_bench;
  localparam int LAT = 13;
  localparam int SBN = 1024;
  localparam int NVEC = 13;
  // {raw, ofs, gain, expected}
  localparam logic [47:0] VEC [NVEC] = '{
    {12'h3E8, 12'h000, 12'h800, 12'h3E8},
    {12'h3E8, 12'h064, 12'h800, 12'h44C},
    {12'h3E8, 12'hF38, 12'h800, 12'h320},
    {12'h032, 12'hF9C, 12'hC00, 12'h000},
    {12'hFA0, 12'h0C8, 12'h800, 12'hFFF},
    {12'h7D0, 12'h000, 12'hC00, 12'hBB8},
    {12'hBB8, 12'h000, 12'hC00, 12'hFFF},
    {12'h3E9, 12'h000, 12'h400, 12'h1F4},
    {12'h800, 12'h7FF, 12'hFFF, 12'hFFF},
    {12'h003, 12'h000, 12'h801, 12'h003},
    {12'h064, 12'h800, 12'h800, 12'h000},
    {12'h3E8, 12'h000, 12'h000, 12'h000},
    {12'h3E8, 12'h064, 12'hC00, 12'h672}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, flush = 1'b0, vld = 1'b0;
  logic [11:0] raw = '0, ofs = '0, gain = '0;
  logic vld_o;
  logic [11:0] res_o;

  int errs = 0, checks = 0, cyc = 0;
  bit done = 1'b0;
  bit sb_v [SBN];
  logic [11:0] sb_d [SBN];
  string sb_t [SBN];

  always #2.5 clk = ~clk;

  cal_corr_stage u_cal_corr_stage (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .flush_i(flush), .vld_i(vld),
    .raw_i(raw), .ofs_i(ofs), .gain_i(gain), .vld_o(vld_o), .res_o(res_o)
  );

  function automatic logic [11:0] ref_calc(logic [11:0] r, logic [11:0] o, logic [11:0] g);
    int s, p;
    s = int'(r) + int'($signed(o));
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    p = (s * int'(g)) >>> 11;
    if (p > 4095) p = 4095;
    return 12'(p);
  endfunction

  task automatic check(bit ok, string tag, logic av, logic [11:0] ad, logic ev, logic [11:0] ed);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cyc=%0d: vld_o=%0b res_o=%0d expected vld=%0b res=%0d",
               tag, cyc, av, ad, ev, ed);
    end
  endtask

  task automatic step(bit e, bit f, bit v, logic [11:0] r, logic [11:0] o,
                      logic [11:0] g, logic [11:0] xp, string tag);
    int ix;
    @(negedge clk);
    en = e; flush = f; vld = v; raw = r; ofs = o; gain = g;
    if (!e || f) begin
      for (int k = 1; k <= LAT; k++) sb_v[(cyc + k) % SBN] = 1'b0;
    end else if (v) begin
      ix = (cyc + LAT) % SBN;
      sb_v[ix] = 1'b1; sb_d[ix] = xp; sb_t[ix] = tag;
    end
    #1;
    ix = cyc % SBN;
    if (!e) begin
      check(vld_o == v && res_o == r, "R6 bypass", vld_o, res_o, v, r);
    end else if (sb_v[ix]) begin
      check(vld_o === 1'b1 && res_o === sb_d[ix], sb_t[ix], vld_o, res_o, 1'b1, sb_d[ix]);
    end else begin
      check(vld_o === 1'b0, (f || tag == "R8") ? tag : "R4 no result expected", vld_o, res_o, 1'b0, 12'd0);
    end
    sb_v[ix] = 1'b0;
    cyc++;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 12'd0, 12'd0, 12'h800, 12'd0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SBN; i++) begin sb_v[i] = 1'b0; sb_d[i] = '0; sb_t[i] = ""; end
    repeat (3) @(negedge clk);
    #1 check(vld_o === 1'b0, "R9 in reset", vld_o, res_o, 1'b0, 12'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(vld_o === 1'b0, "R9 after reset", vld_o, res_o, 1'b0, 12'd0);

    // table walk: single samples, arithmetic and exact latency (R1 R2 R3 R4)
    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, 1'b0, 1'b1, VEC[i][47:36], VEC[i][35:24], VEC[i][23:12], VEC[i][11:0],
           "R1 R2 R3 table");
      idle(LAT, "R4");
    end

    // back-to-back burst with per-sample coefficients (R5)
    for (int i = 0; i < 24; i++) begin
      logic [11:0] r, o, g;
      r = 12'(i * 397 + 5); o = 12'(i * 173); g = 12'(12'h600 + i * 37);
      step(1'b1, 1'b0, 1'b1, r, o, g, ref_calc(r, o, g), "R5 burst");
    end
    idle(LAT + 1, "R5");

    // flush mid-stream (R7)
    for (int i = 0; i < 6; i++)
      step(1'b1, 1'b0, 1'b1, 12'(100 + i), 12'd0, 12'h800, 12'(100 + i), "R7 lost");
    step(1'b1, 1'b1, 1'b1, 12'd999, 12'd0, 12'h800, 12'd999, "R7 flush");
    for (int i = 0; i < 3; i++)
      step(1'b1, 1'b0, 1'b1, 12'(200 + i), 12'd5, 12'h800, 12'(205 + i), "R7 after flush");
    idle(LAT + 1, "R7");

    // disable with samples in flight (R6 R8)
    for (int i = 0; i < 5; i++)
      step(1'b1, 1'b0, 1'b1, 12'(300 + i), 12'd0, 12'h800, 12'(300 + i), "R8 lost");
    step(1'b0, 1'b0, 1'b1, 12'hABC, 12'h123, 12'h456, 12'hABC, "R6");
    step(1'b0, 1'b0, 1'b0, 12'h5A5, 12'd0, 12'h800, 12'h5A5, "R6");
    step(1'b0, 1'b0, 1'b1, 12'hFFF, 12'h7FF, 12'hFFF, 12'hFFF, "R6");
    idle(LAT + 1, "R8");
    step(1'b1, 1'b0, 1'b1, 12'd700, 12'hF9C, 12'hC00, ref_calc(12'd700, 12'hF9C, 12'hC00), "R8 restart");
    idle(LAT + 1, "R4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule